// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block turns an operand specifier into a memory address. It takes a mode code, a base and an index register value, a 16-bit displacement, an absolute address field and an operand-size code. It then returns the operand's effective address, together with any new value the base register must receive. Most modes finish one cycle after `start`.

Memory-indirect mode takes two steps. The block first fetches a pointer over a small valid/ready request port and a valid-only response port. It then returns that pointer as the operand address.

Register storage, instruction decode and the operation on the fetched operand stay with the surrounding pipeline. For register and immediate operands the block only reports that no memory access is needed.

Top module: `eag_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `done`, `busy`, `wb_en`, `nomem` and `mem_req_valid` are 0, and `ea` and `wb_val` are 0.
- R2: Displacement mode (code 2) gives `ea` = `base` + the sign-extended 16-bit `disp`, with `done` high in the cycle after the cycle in which `start` is sampled.
- R3: Register-indirect mode (code 3) gives `ea` = `base`. Indexed mode (code 4) gives `ea` = `base` + `index`.
- R4: Absolute mode (code 5) gives `ea` = `abs_addr` unchanged.
- R5: Auto-increment mode (code 7) gives `ea` = the old `base` and `wb_val` = `base` + d, with `wb_en` high.
- R6: Auto-decrement mode (code 8) gives `ea` = `wb_val` = `base` − d, with `wb_en` high.
- R7: Operand-size code `size` 0, 1 and 2 gives d = 1, 2 and 4 bytes. Code 3 gives d = 4. Scaled mode (code 9) gives `ea` = sign-extended `disp` + `base` + `index`·d.
- R8: Memory-indirect mode (code 6) raises `busy` and `mem_req_valid` in the cycle after `start`, with `mem_req_addr` = `base`. `busy` stays high until the cycle in which `mem_rsp_valid` is sampled. In the next cycle `done` is high, `busy` is low, `ea` equals the sampled `mem_rsp_data`, and `wb_en` is 0.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and `mem_req_addr` stays unchanged. A request is accepted in the cycle where both are high.
- R10: A `start` sampled while `busy` is high is ignored: it produces no `done` and does not alter the pending result.
- R11: Register mode (code 0), immediate mode (code 1) and the unused codes 10–15 give `nomem` = 1, `ea` = 0 and `wb_en` = 0, with `done` in the next cycle.
- R12: `wb_en` is high only together with `done`, and only for codes 7 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation with the operand fields below |
| mode | input | 4 | Addressing mode code |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| disp | input | 16 | Displacement, two's complement |
| abs_addr | input | 32 | Absolute address field |
| size | input | 2 | Operand size code (log2 of bytes) |
| done | output | 1 | One-cycle pulse: result valid |
| busy | output | 1 | Pointer fetch in progress |
| ea | output | 32 | Effective address |
| nomem | output | 1 | With done: operand needs no memory access |
| wb_en | output | 1 | With done: write `wb_val` to the base register |
| wb_val | output | 32 | New base register value |
| mem_req_valid | output | 1 | Pointer fetch request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Pointer fetch address |
| mem_rsp_valid | input | 1 | Pointer data returned |
| mem_rsp_data | input | 32 | Pointer value |

## Verification
The assertions assume the memory returns exactly one `mem_rsp_valid` pulse per accepted request, and only after the request is accepted. They also assume operand fields are stable in the cycle `start` is sampled. The bench's memory model raises `ready` only after stalling, drops it after acceptance, and returns a single response pulse a few cycles later. It issues `start` only when the block is idle, except in the one test that deliberately pulses `start` during a fetch to check that it is ignored.

// File: rtl/eag_pkg.sv
`timescale 1ns/1ps
package eag_pkg;

    localparam int unsigned EAG_AW = 32;
    localparam int unsigned EAG_DW = 16;
    localparam int unsigned EAG_MW = 4;
    localparam int unsigned EAG_SW = 2;

    typedef enum logic [EAG_MW-1:0] {
        AM_REG   = 4'd0,
        AM_IMM   = 4'd1,
        AM_DISP  = 4'd2,
        AM_RIND  = 4'd3,
        AM_INDEX = 4'd4,
        AM_ABS   = 4'd5,
        AM_MIND  = 4'd6,
        AM_AINC  = 4'd7,
        AM_ADEC  = 4'd8,
        AM_SCALE = 4'd9
    } amode_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_WAIT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic wb_en;
        logic nomem;
        logic indirect;
    } ea_ctl_t;

    // Size code 3 is folded onto the largest legal size.
    function automatic logic [EAG_SW-1:0] size_shift(input logic [EAG_SW-1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

endpackage

// File: rtl/eag_scale.sv
`timescale 1ns/1ps
module eag_scale #(
    parameter int unsigned AW = 32,
    parameter int unsigned SW = 2
) (
    input  logic [AW-1:0] value,
    input  logic [SW-1:0] shamt,
    output logic [AW-1:0] scaled
);
    localparam int unsigned NSTEP = 1 << SW;

    logic [AW-1:0] opts [NSTEP];

    for (genvar g = 0; g < NSTEP; g++) begin : g_opt
        assign opts[g] = value << g;
    end

    assign scaled = opts[shamt];
endmodule

// File: rtl/eag_addr.sv
`timescale 1ns/1ps
module eag_addr
    import eag_pkg::*;
#(
    parameter int unsigned AW = EAG_AW,
    parameter int unsigned DW = EAG_DW,
    parameter int unsigned MW = EAG_MW,
    parameter int unsigned SW = EAG_SW
) (
    input  logic [MW-1:0] mode,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] index,
    input  logic [DW-1:0] disp,
    input  logic [AW-1:0] abs_addr,
    input  logic [SW-1:0] size,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] wb_val,
    output ea_ctl_t       ctl
);
    localparam int unsigned XW = AW - DW;

    logic [SW-1:0] shamt;
    logic [AW-1:0] disp_x;
    logic [AW-1:0] step;
    logic [AW-1:0] idx_sc;
    logic [AW-1:0] base_dec;
    amode_e        am;

    assign shamt    = size_shift(size);
    assign disp_x   = {{XW{disp[DW-1]}}, disp};
    assign step     = AW'(1) << shamt;
    assign base_dec = base - step;
    assign am       = amode_e'(mode);

    eag_scale #(.AW(AW), .SW(SW)) u_scale (
        .value  (index),
        .shamt  (shamt),
        .scaled (idx_sc)
    );

    always_comb begin
        ea      = '0;
        wb_val  = '0;
        ctl     = '{wb_en: 1'b0, nomem: 1'b0, indirect: 1'b0};
        case (am)
            AM_DISP:  ea = base + disp_x;
            AM_RIND:  ea = base;
            AM_INDEX: ea = base + index;
            AM_ABS:   ea = abs_addr;
            AM_MIND: begin
                ea           = base;
                ctl.indirect = 1'b1;
            end
            AM_AINC: begin
                ea        = base;
                wb_val    = base + step;
                ctl.wb_en = 1'b1;
            end
            AM_ADEC: begin
                ea        = base_dec;
                wb_val    = base_dec;
                ctl.wb_en = 1'b1;
            end
            AM_SCALE: ea = disp_x + base + idx_sc;
            default:  ctl.nomem = 1'b1;
        endcase
    end
endmodule

// File: rtl/eag_seq.sv
`timescale 1ns/1ps
module eag_seq
    import eag_pkg::*;
#(
    parameter int unsigned AW = EAG_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] ea_in,
    input  logic [AW-1:0] wb_in,
    input  ea_ctl_t       ctl_in,
    output logic          done,
    output logic          busy,
    output logic [AW-1:0] ea,
    output logic          nomem,
    output logic          wb_en,
    output logic [AW-1:0] wb_val,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [AW-1:0] mem_rsp_data
);
    seq_state_e    state;
    logic [AW-1:0] ptr_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            ptr_addr <= '0;
            ea       <= '0;
            wb_val   <= '0;
            done     <= 1'b0;
            nomem    <= 1'b0;
            wb_en    <= 1'b0;
        end else begin
            done  <= 1'b0;
            nomem <= 1'b0;
            wb_en <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        if (ctl_in.indirect) begin
                            state    <= SQ_REQ;
                            ptr_addr <= ea_in;
                        end else begin
                            done   <= 1'b1;
                            ea     <= ea_in;
                            wb_val <= wb_in;
                            wb_en  <= ctl_in.wb_en;
                            nomem  <= ctl_in.nomem;
                        end
                    end
                end
                SQ_REQ: begin
                    if (mem_req_ready) state <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (mem_rsp_valid) begin
                        ea    <= mem_rsp_data;
                        done  <= 1'b1;
                        state <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign busy          = (state != SQ_IDLE);
    assign mem_req_valid = (state == SQ_REQ);
    assign mem_req_addr  = ptr_addr;

    a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r8_req_in_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> busy);

    a_r12_wb_with_done: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> done);

    a_r11_nomem_no_wb: assert property (@(posedge clk) disable iff (rst)
        nomem |-> (done && !wb_en));

    a_r10_busy_start_no_done: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_rsp_valid) |=> !done);
endmodule

// File: rtl/eag_top.sv
`timescale 1ns/1ps
module eag_top
    import eag_pkg::*;
#(
    parameter int unsigned AW = EAG_AW,
    parameter int unsigned DW = EAG_DW,
    parameter int unsigned MW = EAG_MW,
    parameter int unsigned SW = EAG_SW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [MW-1:0] mode,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] index,
    input  logic [DW-1:0] disp,
    input  logic [AW-1:0] abs_addr,
    input  logic [SW-1:0] size,
    output logic          done,
    output logic          busy,
    output logic [AW-1:0] ea,
    output logic          nomem,
    output logic          wb_en,
    output logic [AW-1:0] wb_val,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [AW-1:0] mem_rsp_data
);
    logic [AW-1:0] calc_ea;
    logic [AW-1:0] calc_wb;
    ea_ctl_t       calc_ctl;

    eag_addr #(.AW(AW), .DW(DW), .MW(MW), .SW(SW)) u_addr (
        .mode     (mode),
        .base     (base),
        .index    (index),
        .disp     (disp),
        .abs_addr (abs_addr),
        .size     (size),
        .ea       (calc_ea),
        .wb_val   (calc_wb),
        .ctl      (calc_ctl)
    );

    eag_seq #(.AW(AW)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .ea_in         (calc_ea),
        .wb_in         (calc_wb),
        .ctl_in        (calc_ctl),
        .done          (done),
        .busy          (busy),
        .ea            (ea),
        .nomem         (nomem),
        .wb_en         (wb_en),
        .wb_val        (wb_val),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    a_r5_autoinc_wb: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && mode == AM_AINC) |=> (done && wb_en));

    a_r6_autodec_wb: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && mode == AM_ADEC) |=> (done && wb_en && ea == wb_val));

    a_r8_indirect_req: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && mode == AM_MIND) |=> (busy && mem_req_valid && mem_req_addr == $past(base)));

    a_r2_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && mode != AM_MIND) |=> done);
endmodule

// File: tb/eag_top_test.sv
`timescale 1ns/1ps
module eag_top_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [3:0]  mode;
    logic [31:0] base, index, abs_addr;
    logic [15:0] disp;
    logic [1:0]  size;
    logic        done, busy, nomem, wb_en, mem_req_valid;
    logic [31:0] ea, wb_val, mem_req_addr;
    logic        mem_req_ready, mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    eag_top uut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .base(base),
        .index(index), .disp(disp), .abs_addr(abs_addr), .size(size),
        .done(done), .busy(busy), .ea(ea), .nomem(nomem), .wb_en(wb_en),
        .wb_val(wb_val), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] sx(input logic [15:0] d);
        return {{16{d[15]}}, d};
    endfunction

    function automatic logic [31:0] dbytes(input logic [1:0] c);
        return (c == 2'd0) ? 32'd1 : (c == 2'd1) ? 32'd2 : 32'd4;
    endfunction

    // Pulse start for one cycle; outputs are sampled at the following negedge.
    task automatic issue(input logic [3:0] m, input logic [31:0] b, input logic [31:0] x,
                         input logic [15:0] d, input logic [31:0] a, input logic [1:0] s);
        @(negedge clk);
        mode = m; base = b; index = x; disp = d; abs_addr = a; size = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic check_result(input string req, input logic [31:0] exp_ea,
                                input logic exp_wb_en, input logic [31:0] exp_wb,
                                input logic exp_nomem);
        chk({req, " done"}, {31'd0, done}, 32'd1);
        chk({req, " ea"}, ea, exp_ea);
        chk({req, " wb_en"}, {31'd0, wb_en}, {31'd0, exp_wb_en});
        if (exp_wb_en) chk({req, " wb_val"}, wb_val, exp_wb);
        chk({req, " nomem"}, {31'd0, nomem}, {31'd0, exp_nomem});
    endtask

    task automatic test_reset();
        rst = 1'b1; start = 1'b0; mode = '0; base = '0; index = '0; disp = '0;
        abs_addr = '0; size = '0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
        mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 wb_en", {31'd0, wb_en}, 32'd0);
        chk("R1 nomem", {31'd0, nomem}, 32'd0);
        chk("R1 req", {31'd0, mem_req_valid}, 32'd0);
        chk("R1 ea", ea, 32'd0);
        chk("R1 wb_val", wb_val, 32'd0);
    endtask

    task automatic test_disp();
        issue(4'd2, 32'h0000_1000, 32'h0, 16'h0064, 32'h0, 2'd0);
        check_result("R2 pos", 32'h0000_1064, 1'b0, 32'h0, 1'b0);
        issue(4'd2, 32'h0000_1000, 32'h0, 16'hFFF0, 32'h0, 2'd0);
        check_result("R2 neg", 32'h0000_1000 + sx(16'hFFF0), 1'b0, 32'h0, 1'b0);
        @(negedge clk);
        chk("R2 one pulse", {31'd0, done}, 32'd0);
    endtask

    task automatic test_rind_index();
        issue(4'd3, 32'hDEAD_0000, 32'h0000_0010, 16'h7777, 32'h0, 2'd2);
        check_result("R3 rind", 32'hDEAD_0000, 1'b0, 32'h0, 1'b0);
        issue(4'd4, 32'h0001_0000, 32'h0000_0234, 16'h0, 32'h0, 2'd2);
        check_result("R3 index", 32'h0001_0234, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic test_abs();
        issue(4'd5, 32'h1111_1111, 32'h2222_2222, 16'h1234, 32'hCAFE_F00D, 2'd1);
        check_result("R4 abs", 32'hCAFE_F00D, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic test_autoinc();
        for (int s = 0; s < 3; s++) begin
            issue(4'd7, 32'h0000_2000, 32'h0, 16'h0, 32'h0, 2'(s));
            check_result("R5 R12 ainc", 32'h0000_2000, 1'b1, 32'h0000_2000 + dbytes(2'(s)), 1'b0);
        end
    endtask

    task automatic test_autodec();
        issue(4'd8, 32'h0000_3000, 32'h0, 16'h0, 32'h0, 2'd2);
        check_result("R6 R12 adec", 32'h0000_2FFC, 1'b1, 32'h0000_2FFC, 1'b0);
        issue(4'd8, 32'h0000_0000, 32'h0, 16'h0, 32'h0, 2'd0);
        check_result("R6 wrap", 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic test_scaled();
        for (int s = 0; s < 4; s++) begin
            issue(4'd9, 32'h0000_4000, 32'h0000_0013, 16'hFFFC, 32'h0, 2'(s));
            check_result("R7 scaled",
                         sx(16'hFFFC) + 32'h0000_4000 + 32'h13 * dbytes(2'(s)),
                         1'b0, 32'h0, 1'b0);
        end
    endtask

    task automatic test_nomem();
        logic [3:0] codes [3] = '{4'd0, 4'd1, 4'd12};
        foreach (codes[i]) begin
            issue(codes[i], 32'h5555_0000, 32'h1, 16'h1, 32'h1, 2'd0);
            check_result("R11 R12 nomem", 32'h0, 1'b0, 32'h0, 1'b1);
        end
    endtask

    task automatic test_indirect();
        issue(4'd6, 32'h0000_8000, 32'h0, 16'h0, 32'h0, 2'd2);
        chk("R8 busy", {31'd0, busy}, 32'd1);
        chk("R8 req", {31'd0, mem_req_valid}, 32'd1);
        chk("R8 addr", mem_req_addr, 32'h0000_8000);
        chk("R8 no done", {31'd0, done}, 32'd0);
        // stalled request while an ignored start arrives
        issue(4'd5, 32'h0, 32'h0, 16'h0, 32'h0BAD_0BAD, 2'd0);
        chk("R10 no done", {31'd0, done}, 32'd0);
        chk("R9 held", {31'd0, mem_req_valid}, 32'd1);
        chk("R9 addr", mem_req_addr, 32'h0000_8000);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk("R9 accepted", {31'd0, mem_req_valid}, 32'd0);
        chk("R8 busy wait", {31'd0, busy}, 32'd1);
        @(negedge clk);
        chk("R8 busy wait2", {31'd0, busy}, 32'd1);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 32'h1234_5678;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = 32'h0;
        chk("R8 busy low", {31'd0, busy}, 32'd0);
        check_result("R8 R10 final", 32'h1234_5678, 1'b0, 32'h0, 1'b0);
        @(negedge clk);
        chk("R8 one pulse", {31'd0, done}, 32'd0);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        test_reset();
        test_disp();
        test_rind_index();
        test_abs();
        test_autoinc();
        test_autodec();
        test_scaled();
        test_nomem();
        test_indirect();
        summary();
    end
endmodule